// File: doc/BRIEF.md
# Four-Source Interrupt Register Bank

This block collects interrupts for a serial peripheral. Four sources feed it: transmit watermark, receive watermark, transmit empty and receive overflow. Each source arrives as a one-cycle hardware pulse and sets a sticky pending bit. Software reaches three 32-bit registers over a simple word-addressed bus. The pending register clears on a write of one. The mask register gates each pending bit onto its own interrupt line. A write-only inject register lets software raise any pending bit as though hardware had fired it.

Each source drives its own level output. An output is the registered AND of its pending bit and its mask bit. Reads are combinational: a read request returns data in the same cycle it is presented.

Top module: `irq_bank_top`

## Requirements
- R1: After reset, the pending and mask registers read as zero and all four interrupt outputs are low.
- R2: A one-cycle pulse on `src_event_i[i]` sets pending bit i at that clock edge. The bit positions are: 0 transmit watermark, 1 receive watermark, 2 transmit empty, 3 receive overflow.
- R3: A write to byte address 0x00 (pending register) clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R4: A write to byte address 0x08 (inject register) ORs bits 3:0 of the written value into the pending register.
- R5: A write to byte address 0x04 (mask register) loads bits 3:0 of the written value, and a read of 0x04 returns them.
- R6: `irq_o[i]` equals the AND of pending bit i and mask bit i as they stood before the previous clock edge. It therefore changes one edge after the register change.
- R7: When a hardware pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R8: A read of the inject register at 0x08 returns zero.
- R9: Bits 31:4 of every register read as zero. Writing ones to those bits has no effect.
- R10: A pending bit holds its value with no event present until a clearing write reaches it.
- R11: A read of any other address returns zero, and a write to any other address changes no register. `rsp_rdata_o` is zero whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Byte address of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| src_event_i | input | 4 | One-cycle event pulse per source |
| irq_o | output | 4 | Level interrupt per source |

## Verification
Two functions can act on the same pending bit in the same cycle. One is a hardware event pulse; the other is a software clearing write or an inject write. The bench provokes this directly by asserting an event on a bit in the same cycle as a pending-register write that clears that bit. It also runs a long pseudo-random stretch in which events, clears, injects and mask writes overlap freely. A behavioural reference model judges every cycle, with the event taking priority over the clear, and compares the outputs and every read against it.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;

  localparam logic [ADDR_W-1:0] OFF_PENDING = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK    = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_INJECT  = 6'h08;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PENDING,
    SEL_MASK,
    SEL_INJECT
  } reg_sel_e;

  // Next value of one sticky bit: the clear acts first, then set and event win.
  function automatic logic sticky_next(input logic cur, input logic evt,
                                       input logic clr, input logic set);
    return (cur & ~clr) | set | evt;
  endfunction
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
(
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_pending_o,
  output logic              wr_mask_o,
  output logic              wr_inject_o,
  output logic              rd_o
);
  always_comb begin
    unique case (req_addr_i)
      OFF_PENDING: sel_o = SEL_PENDING;
      OFF_MASK:    sel_o = SEL_MASK;
      OFF_INJECT:  sel_o = SEL_INJECT;
      default:     sel_o = SEL_NONE;
    endcase
  end

  logic wr_any;
  assign wr_any       = req_valid_i & req_write_i;
  assign rd_o         = req_valid_i & ~req_write_i;
  assign wr_pending_o = wr_any & (sel_o == SEL_PENDING);
  assign wr_mask_o    = wr_any & (sel_o == SEL_MASK);
  assign wr_inject_o  = wr_any & (sel_o == SEL_INJECT);
endmodule

// File: rtl/irq_bank_state.sv
module irq_bank_state #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] set_i,
  output logic [NUM_SRC-1:0] pending_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pending_o[i] <= 1'b0;
      else         pending_o[i] <= irq_bank_pkg::sticky_next(pending_o[i], event_i[i],
                                                             clr_i[i], set_i[i]);
    end

    // R2
    event_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[i] |=> pending_o[i]);

    // R7
    event_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (event_i[i] && clr_i[i]) |=> pending_o[i]);

    // R3
    w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i] && !event_i[i]) |=> !pending_o[i]);

    // R4
    inject_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pending_o[i]);

    // R10
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pending_o[i] && !clr_i[i]) |=> pending_o[i]);

    // R10
    rise_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pending_o[i]) |-> $past(event_i[i] || set_i[i]));
  end
endmodule

// File: rtl/irq_bank_mask.sv
module irq_bank_mask #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pending_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= pending_i & mask_i;
  end

  // R6
  irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(mask_i)) == '0);

  // R6
  irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(pending_i)) == '0);
endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = irq_bank_pkg::NUM_SRC,
  parameter int DATA_W  = irq_bank_pkg::DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic                      req_write_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic [DATA_W-1:0]         rsp_rdata_o,
  input  logic [NUM_SRC-1:0]        src_event_i,
  output logic [NUM_SRC-1:0]        irq_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  reg_sel_e           sel;
  logic               wr_pending, wr_mask, wr_inject, rd;
  logic [NUM_SRC-1:0] wlow;
  logic [NUM_SRC-1:0] clr_bits, set_bits;
  logic [NUM_SRC-1:0] pending_q, mask_q;

  assign wlow     = req_wdata_i[NUM_SRC-1:0];
  assign clr_bits = wr_pending ? wlow : '0;
  assign set_bits = wr_inject  ? wlow : '0;

  irq_bank_decode u_decode (
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .sel_o       (sel),
    .wr_pending_o(wr_pending),
    .wr_mask_o   (wr_mask),
    .wr_inject_o (wr_inject),
    .rd_o        (rd)
  );

  irq_bank_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (src_event_i),
    .clr_i    (clr_bits),
    .set_i    (set_bits),
    .pending_o(pending_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wlow;
  end

  irq_bank_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pending_i(pending_q),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rsp_rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_PENDING: rsp_rdata_o = {{PAD_W{1'b0}}, pending_q};
        SEL_MASK:    rsp_rdata_o = {{PAD_W{1'b0}}, mask_q};
        default:     rsp_rdata_o = '0;
      endcase
    end
  end

  // R5
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_q == $past(wlow)));

  // R11
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));

  // R9
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_rdata_o[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: tb/tb_irq_bank_top.sv
`timescale 1ns/1ps
module tb_irq_bank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0, w = 1'b0;
  logic [5:0]  a = '0;
  logic [31:0] d = '0;
  logic [3:0]  e = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference
  logic [3:0] m_pend = '0, m_mask = '0, m_irq = '0;

  always #2 clk = ~clk;

  irq_bank_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_write_i(w),
    .req_addr_i(a), .req_wdata_i(d), .rsp_rdata_o(rdata),
    .src_event_i(e), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_mask = 0; m_irq = 0;
    end else begin
      m_irq = m_pend & m_mask;
      if (v && w && a == 6'h00) m_pend = m_pend & ~d[3:0];
      if (v && w && a == 6'h08) m_pend = m_pend | d[3:0];
      m_pend = m_pend | e;
      if (v && w && a == 6'h04) m_mask = d[3:0];
    end
  end

  function automatic logic [31:0] model_read(input logic [5:0] addr);
    if (addr == 6'h00) return {28'd0, m_pend};
    if (addr == 6'h04) return {28'd0, m_mask};
    return 32'd0;
  endfunction

  // R6: output compared against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        failures++;
        $display("FAIL R6 irq_o actual=%h expected=%h t=%0t", irq, m_irq, $time);
      end
    end
  end

  task automatic cyc(input logic vv, input logic ww, input logic [5:0] aa,
                     input logic [31:0] dd, input logic [3:0] ee, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    v = vv; w = ww; a = aa; d = dd; e = ee;
    #1;
    if (vv && !ww) exp = model_read(aa);
    else           exp = 32'd0;
    checks++;
    if (rdata !== exp) begin
      failures++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, aa, rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 6'h00, 0, 4'h0, "R11");
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    cyc(1, 0, 6'h00, 0, 0, "R1");
    cyc(1, 0, 6'h04, 0, 0, "R1");

    // R2 each source alone, then R10 held
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 6'h00, 0, 4'(1 << i), "R2");
      cyc(1, 0, 6'h00, 0, 0, "R2");
    end
    idle(3);
    cyc(1, 0, 6'h00, 0, 0, "R10");

    // R5 / R9 mask with upper bits set
    cyc(1, 1, 6'h04, 32'hFFFF_FFF5, 0, "R5");
    cyc(1, 0, 6'h04, 0, 0, "R9");
    idle(2);

    // R3 write one to clear
    cyc(1, 1, 6'h00, 32'h0000_0003, 0, "R3");
    cyc(1, 0, 6'h00, 0, 0, "R3");
    cyc(1, 1, 6'h00, 32'h0000_0000, 0, "R3");
    cyc(1, 0, 6'h00, 0, 0, "R3");

    // R4 inject, R8 inject reads zero
    cyc(1, 1, 6'h08, 32'h0000_000A, 0, "R4");
    cyc(1, 0, 6'h00, 0, 0, "R4");
    cyc(1, 0, 6'h08, 0, 0, "R8");

    // R7 event and clear on the same bit in the same cycle
    cyc(1, 1, 6'h00, 32'hF, 4'b0010, "R7");
    cyc(1, 0, 6'h00, 0, 0, "R7");
    cyc(1, 1, 6'h00, 32'hF, 4'b0000, "R3");
    cyc(1, 0, 6'h00, 0, 0, "R3");

    // R9 upper bits of inject / clear are ignored
    cyc(1, 1, 6'h08, 32'hFFFF_FFF0, 0, "R9");
    cyc(1, 0, 6'h00, 0, 0, "R9");

    // R11 unmapped address
    cyc(1, 1, 6'h0C, 32'hF, 0, "R11");
    cyc(1, 1, 6'h3C, 32'hF, 0, "R11");
    cyc(1, 0, 6'h0C, 0, 0, "R11");
    cyc(1, 0, 6'h04, 0, 0, "R11");
    cyc(1, 0, 6'h00, 0, 0, "R11");

    // R6 mixed overlapping traffic
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 400; k++) begin
      logic [5:0] addr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      unique case (lfsr[3:2])
        2'd0: addr = 6'h00;
        2'd1: addr = 6'h04;
        2'd2: addr = 6'h08;
        default: addr = 6'h10;
      endcase
      cyc(lfsr[4], lfsr[5], addr, {lfsr[27:0], lfsr[31:28]},
          lfsr[9:6] & {4{lfsr[10]}}, "R6");
    end
    idle(3);
    finish_run();
  end
endmodule